// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the slave-side responder that lets a host find out which device on a shared two-wire bus raised an alert, and why. When the host reads the bus-wide alert response address, every device with a pending alert acknowledges. Each of those devices then sends back an identification byte. The upper nibble of that byte is the device's strap identifier and the lower bits carry the number of the channel that caused the alert. The line is open-drain, so the responders compete through wired-AND arbitration. Any responder that sends a one but sees a zero on the line drops out. It releases SDA for the rest of the byte and raises a flag. The device with the lowest byte therefore reaches the host intact.

The block takes SCL and SDA levels that have already been synchronised to its clock, and derives START, STOP and clock edges from them. It also takes the alert-pending flag, the offending channel and the strap identifier. It only ever pulls SDA low through `sda_drive_low`. It never clears the alert. Clearing the alert is the job of the device's normal addressed-read path, and this sequence leaves the alert untouched.

Top module: `ara_responder`

## Requirements
- R1: After reset, `sda_drive_low` and `arb_lost` are both 0.
- R2: A first byte equal to 0x19 (seven-bit address 0001100, read bit 1), received while `alert_pending` is 1 and `dev_id` is nonzero, is acknowledged. The responder holds SDA low for the whole ninth clock.
- R3: When `alert_pending` is 0 at the end of the first byte, the responder never pulls SDA low during that transaction.
- R4: Any first byte other than 0x19 is not acknowledged, including 0x18 (the same address with a write bit). The responder stays silent until the next START.
- R5: After the acknowledge, the responder sends the byte {dev_id[3:0], 0, channel[1:0], 1} MSB first. Each bit is placed after an SCL fall and is held through the following SCL high phase.
- R6: Once the eighth reply bit has been clocked, SDA is released for the host's acknowledge bit. It stays released for any further clocks until a new START.
- R7: During the reply, if the responder is sending a 1 but samples SDA at 0 on an SCL rise, it releases SDA for the rest of the byte and sets `arb_lost`.
- R8: `arb_lost` stays at 1 through STOP and is cleared only by the next START.
- R9: With `dev_id` equal to zero, which is a forbidden strap value, the responder never acknowledges.
- R10: A START at any point, including a repeated START in the middle of the address byte, restarts address recognition. A STOP releases SDA at once.
- R11: `sda_drive_low` only goes from 0 to 1 while SCL is low.
- R12: The channel is captured when the acknowledge is given. Changes to `alert_channel` or `alert_pending` after that point do not alter the reply byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level, as seen on the wired bus |
| alert_pending | input | 1 | The device has an alert outstanding |
| alert_channel | input | CH_W (2) | Channel that caused the alert |
| dev_id | input | ID_W (4) | Strap identifier, upper part of the reply byte |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| arb_lost | output | 1 | Arbitration was lost during the last reply |

## Verification
The bench builds the block with its default widths: a 4-bit identifier and a 2-bit channel, which gives an 8-bit reply that matches a bus byte, and the standard alert response address. At these widths every channel code and both ends of the identifier range can be exercised. That includes the forbidden zero strap and the all-ones identifier. A second, modelled open-drain device on the same wire takes part in arbitration, which makes the drop-out point and the winner's byte observable on the bus. Repeated START, a host ACK after the reply, and late changes to the channel are driven as directed cases.

// File: rtl/ara_pkg.sv
`timescale 1ns/1ps
package ara_pkg;

    // Width of one bus byte (address phase and reply phase alike).
    localparam int FRAME_W = 8;

    // Alert response address, seven bits, read direction appended below.
    localparam logic [6:0] ARA_ADDR7 = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // collecting the first byte
        ST_ACK,    // holding SDA low during the ninth clock
        ST_TX,     // shifting out the reply byte
        ST_HOLD,   // quiet until next START or STOP
        ST_LOST    // dropped out of arbitration
    } ara_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // First byte that selects the responder: address plus read bit.
    function automatic logic [FRAME_W-1:0] ara_read_byte(input logic [6:0] addr7);
        return {addr7, 1'b1};
    endfunction

endpackage

// File: rtl/ara_bus_events.sv
`timescale 1ns/1ps
module ara_bus_events
    import ara_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/ara_rx_shift.sv
`timescale 1ns/1ps
module ara_rx_shift #(
    parameter int            W     = 8,
    parameter logic [W-1:0]  MATCH = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic match
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_q <= '0;
        end else if (sample) begin
            sr_q <= {sr_q[W-2:0], bit_in};
        end
    end

    assign match = (sr_q == MATCH);

endmodule

// File: rtl/ara_tx_shift.sv
`timescale 1ns/1ps
module ara_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         cur_bit,
    output logic         next_bit
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            // Shift in ones so a stray extra bit is recessive.
            sr_q <= {sr_q[W-2:0], 1'b1};
        end
    end

    assign cur_bit  = sr_q[W-1];
    assign next_bit = sr_q[W-2];

endmodule

// File: rtl/ara_responder.sv
`timescale 1ns/1ps
module ara_responder
    import ara_pkg::*;
#(
    parameter int ID_W = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic            alert_pending,
    input  logic [CH_W-1:0] alert_channel,
    input  logic [ID_W-1:0] dev_id,
    output logic            sda_drive_low,
    output logic            arb_lost
);

    // Reply: identifier, a zero separator, channel, recessive last bit.
    localparam int REPLY_W = ID_W + CH_W + 2;
    localparam int CNT_MAX = (REPLY_W > FRAME_W) ? REPLY_W : FRAME_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [FRAME_W-1:0] SEL_BYTE = ara_read_byte(ARA_ADDR7);

    bus_ev_t           ev;
    ara_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              drv_q;
    logic              lost_q;
    logic [CH_W-1:0]   chan_q;
    logic              addr_hit;
    logic              tx_cur;
    logic              tx_next;
    logic              respond;
    logic              rx_sample;
    logic              tx_load;
    logic              tx_shift;
    logic              quiet_ev;
    logic [REPLY_W-1:0] reply_w;

    ara_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign quiet_ev  = ~ev.start & ~ev.stop;
    assign rx_sample = quiet_ev & (st_q == ST_ADDR) & ev.rise;

    ara_rx_shift #(
        .W     (FRAME_W),
        .MATCH (SEL_BYTE)
    ) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (ev.start),
        .sample (rx_sample),
        .bit_in (sda_i),
        .match  (addr_hit)
    );

    assign reply_w  = {dev_id, 1'b0, chan_q, 1'b1};
    assign tx_load  = quiet_ev & (st_q == ST_ACK) & ev.fall;
    assign tx_shift = quiet_ev & (st_q == ST_TX) & ev.fall & ~ev.rise
                    & (cnt_q != CNT_W'(REPLY_W));

    ara_tx_shift #(
        .W (REPLY_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (tx_load),
        .load_val (reply_w),
        .shift    (tx_shift),
        .cur_bit  (tx_cur),
        .next_bit (tx_next)
    );

    // Only a device with an outstanding alert and a legal strap answers.
    assign respond = addr_hit & alert_pending & (dev_id != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            drv_q  <= 1'b0;
            lost_q <= 1'b0;
            chan_q <= '0;
        end else if (ev.stop) begin
            st_q  <= ST_IDLE;
            drv_q <= 1'b0;
        end else if (ev.start) begin
            st_q   <= ST_ADDR;
            cnt_q  <= '0;
            drv_q  <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_ADDR: begin
                    if (ev.rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (ev.fall && cnt_q == CNT_W'(FRAME_W)) begin
                        if (respond) begin
                            st_q   <= ST_ACK;
                            drv_q  <= 1'b1;
                            chan_q <= alert_channel;
                        end else begin
                            st_q <= ST_HOLD;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        st_q  <= ST_TX;
                        cnt_q <= '0;
                        drv_q <= ~reply_w[REPLY_W-1];
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        if (tx_cur && !sda_i) begin
                            st_q   <= ST_LOST;
                            drv_q  <= 1'b0;
                            lost_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else if (ev.fall) begin
                        if (cnt_q == CNT_W'(REPLY_W)) begin
                            st_q  <= ST_HOLD;
                            drv_q <= 1'b0;
                        end else begin
                            drv_q <= ~tx_next;
                        end
                    end
                end
                default: begin
                    drv_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_drive_low = drv_q;
    assign arb_lost      = lost_q;

endmodule

// File: rtl/ara_responder_chk.sv
`timescale 1ns/1ps
module ara_responder_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            scl_i,
    input logic            sda_i,
    input logic [ID_W-1:0] dev_id,
    input logic            sda_drive_low,
    input logic            arb_lost
);

    // R7
    lost_releases_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> !sda_drive_low);

    // R7
    lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> ($past(scl_i) && !$past(sda_i)));

    // R8
    lost_clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(arb_lost) |-> ($past(scl_i) && !$past(sda_i) && $past(sda_i, 2)));

    // R9
    zero_id_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_id == '0) |-> !sda_drive_low);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_drive_low);

    // R11
    drive_on_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !scl_i);

endmodule

bind ara_responder ara_responder_chk #(.ID_W(ID_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .dev_id        (dev_id),
    .sda_drive_low (sda_drive_low),
    .arb_lost      (arb_lost)
);

// File: tb/ara_responder_tb_top.sv
`timescale 1ns/1ps
module ara_responder_tb_top;

    typedef struct packed {
        logic [7:0] first;
        logic       alert;
        logic [3:0] id;
        logic [1:0] ch;
        logic       ack;
        logic [7:0] reply;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h19, 1'b1, 4'h9, 2'd0, 1'b1, 8'h91},
        '{8'h19, 1'b1, 4'h9, 2'd2, 1'b1, 8'h95},
        '{8'h19, 1'b1, 4'hA, 2'd1, 1'b1, 8'hA3},
        '{8'h19, 1'b1, 4'hF, 2'd3, 1'b1, 8'hF7},
        '{8'h19, 1'b0, 4'h9, 2'd1, 1'b0, 8'h00},
        '{8'h18, 1'b1, 4'h9, 2'd1, 1'b0, 8'h00},
        '{8'h99, 1'b1, 4'h9, 2'd1, 1'b0, 8'h00},
        '{8'h19, 1'b1, 4'h0, 2'd2, 1'b0, 8'h00},
        '{8'h19, 1'b1, 4'h1, 2'd3, 1'b1, 8'h17}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       scl;
    logic       m_sda;
    logic       o_sda;
    logic       alert;
    logic [1:0] ch;
    logic [3:0] id;
    logic       drv;
    logic       lost;
    logic       bus;
    int         total = 0;
    int         bad = 0;
    int         drv_cnt = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    assign bus = m_sda & o_sda & ~drv;

    ara_responder dut_i (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (bus),
        .alert_pending (alert),
        .alert_channel (ch),
        .dev_id        (id),
        .sda_drive_low (drv),
        .arb_lost      (lost)
    );

    always @(posedge clk) if (drv) drv_cnt <= drv_cnt + 1;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wt(3);
        scl = 1'b1;   wt(3);
        m_sda = 1'b0; wt(3);
        scl = 1'b0;   wt(3);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(3);
        scl = 1'b1;   wt(3);
        m_sda = 1'b1; wt(3);
    endtask

    task automatic bit_clk(input logic b, output logic s);
        m_sda = b; wt(3);
        scl = 1'b1; wt(2);
        s = bus; wt(2);
        scl = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(v[i], s);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s);
            v[i] = s;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic       n;
        logic [7:0] r;
        int         d0;

        rst = 1'b1; scl = 1'b1; m_sda = 1'b1; o_sda = 1'b1;
        alert = 1'b0; ch = 2'd0; id = 4'h9;
        wt(5);
        chk("R1 drive after reset", drv, 0);
        chk("R1 lost after reset", lost, 0);
        rst = 1'b0;
        wt(3);
        chk("R1 drive idle", drv, 0);

        // Vector table: main function and address / alert / strap filtering.
        for (int k = 0; k < NVEC; k++) begin
            alert = VECS[k].alert; id = VECS[k].id; ch = VECS[k].ch;
            wt(2);
            d0 = drv_cnt;
            bus_start;
            send_byte(VECS[k].first);
            bit_clk(1'b1, a);
            if (VECS[k].ack) begin
                chk("R2 ack", !a, 1);
                read_byte(r);
                chk("R5 reply byte", r, VECS[k].reply);
                bit_clk(1'b1, n);
                chk("R6 released for host ack", n, 1);
            end else begin
                chk("R3/R4/R9 no ack", !a, 0);
                chk("R3 R4 R9 silent", drv_cnt - d0, 0);
            end
            bus_stop;
            chk("R10 released after stop", drv, 0);
        end

        // R12: channel captured at acknowledge.
        alert = 1'b1; id = 4'h5; ch = 2'd1;
        bus_start;
        send_byte(8'h19);
        bit_clk(1'b1, a);
        chk("R12 ack", !a, 1);
        ch = 2'd3; alert = 1'b0;
        read_byte(r);
        chk("R12 reply keeps channel", r, 8'h53);
        bit_clk(1'b1, n);
        bus_stop;
        alert = 1'b1;

        // R6: host acknowledges and keeps clocking; responder stays quiet.
        id = 4'h9; ch = 2'd2;
        bus_start;
        send_byte(8'h19);
        bit_clk(1'b1, a);
        read_byte(r);
        chk("R6 first reply", r, 8'h95);
        bit_clk(1'b0, n);
        read_byte(r);
        chk("R6 quiet after reply", r, 8'hFF);
        bus_stop;

        // R7/R8: lower competitor 0x87 wins against own reply 0x95.
        bus_start;
        send_byte(8'h19);
        bit_clk(1'b1, a);
        chk("R7 ack before contest", !a, 1);
        for (int i = 7; i >= 0; i--) begin
            logic s;
            o_sda = r[0] | 1'b1;
            o_sda = (8'h87 >> i) & 1'b1;
            bit_clk(1'b1, s);
            r[i] = s;
        end
        o_sda = 1'b1;
        chk("R7 winner byte on bus", r, 8'h87);
        chk("R7 lost flag", lost, 1);
        chk("R7 released", drv, 0);
        bit_clk(1'b1, n);
        bus_stop;
        chk("R8 flag held over stop", lost, 1);
        bus_start;
        chk("R8 flag cleared by start", lost, 0);
        send_byte(8'h44);
        bit_clk(1'b1, a);
        bus_stop;

        // R10: repeated START inside the address byte.
        bus_start;
        bit_clk(1'b1, a); bit_clk(1'b0, a); bit_clk(1'b1, a); bit_clk(1'b0, a);
        bus_start;
        send_byte(8'h19);
        bit_clk(1'b1, a);
        chk("R10 ack after repeated start", !a, 1);
        read_byte(r);
        chk("R10 reply after repeated start", r, 8'h95);
        bit_clk(1'b1, n);
        bus_stop;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule